// File: doc/BRIEF.md
# Reciprocal Square Root Estimate Engine

This block computes an 8-bit-precision estimate of one over the square root of a normalized 9-bit operand. It uses integer arithmetic only. After a one-cycle start request, the operand is first conditioned according to its range. A bit-serial search then finds where a cubic product crosses the fixed threshold 2^28. The crossing point is halved to give a 9-bit estimate whose most significant bit is always set. The result comes back with a one-cycle done pulse.

A mode input lets the same engine serve a 32-bit unsigned fixed-point estimate operation. In that mode the operand is taken from the upper nine bits of a 32-bit word. The estimate is returned packed into the upper nine bits of a 32-bit result. A word whose two top bits are both clear saturates to all ones.

Top module: `rsq_core`

## Requirements
- R1: In 9-bit mode the operand is legal in 128..511. For every legal operand the estimate lies in 256..511.
- R2: An operand below 256 is conditioned to p = 2*a+1.
- R3: An operand of 256 or more has its least significant bit cleared, then 1 added, then the sum doubled. As a result, the operands 2k and 2k+1 in that range give the same estimate.
- R4: The estimate equals (b+1)/2, truncated. Here b is the smallest integer of at least 512 for which p*(b+1)*(b+1) is not below 2^28.
- R5: The product comparison is held to at least 30 unsigned bits, so it never wraps. Operand 128 gives 511 and operand 511 gives 256.
- R6: With mode_i = 1, a word_i whose bits 31:30 are both 0 gives word_o = 0xFFFFFFFF and est_o = 0x1FF.
- R7: Otherwise est_o holds the estimate and word_o carries it in bits 31:23, with bits 22:0 zero. With mode_i = 1 the operand is word_i[31:23], and word_i[22:0] has no effect.
- R8: done_o is high for exactly one cycle. That cycle follows the 11th rising edge after the edge that accepts start_i. est_o and word_o change only at that edge.
- R9: start_i is ignored while a computation is in flight. The pending result is not altered, and no extra done_o pulse is produced.
- R10: While reset is applied, done_o, est_o and word_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a computation |
| mode_i | input | 1 | 0: 9-bit operand port, 1: 32-bit unsigned word mode |
| operand_i | input | 9 | Normalized operand for 9-bit mode |
| word_i | input | 32 | Input word for 32-bit mode |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| est_o | output | 9 | Estimate, held until the next result |
| word_o | output | 32 | Packed 32-bit result, held until the next result |

## Verification
Every one of the 384 legal operands is compared against an integer loop that counts b upward from 512. This separates a correct bit-serial search from one that stops a step early or late, or that wraps its product. Adjacent pairs such as 255, 256 and 257 show the two conditioning branches: the two operands above 256 must agree, and 255 must differ from them. In word mode, patterns with top bits 00, 01 and 1x, and with noisy low bits, test saturation, field selection and packing. A second start issued mid-computation must leave the first result and its single done pulse untouched.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BUSY = 2'd1,
        PH_FIN  = 2'd2
    } rsq_phase_e;

endpackage

// File: rtl/rsq_precond.sv
module rsq_precond #(
    parameter int OP_W  = 9,
    parameter int PRE_W = OP_W + 1
) (
    input  logic [OP_W-1:0]  op_i,
    output logic [PRE_W-1:0] pre_o
);
    // upper half: {a[8:1],1,0} equals ((a with lsb cleared)+1)*2
    // lower half: {a,1} equals 2a+1
    always_comb begin
        if (op_i[OP_W-1]) begin
            pre_o = {op_i[OP_W-1:1], 1'b1, 1'b0};
        end else begin
            pre_o = {op_i, 1'b1};
        end
    end
endmodule

// File: rtl/rsq_trial.sv
module rsq_trial #(
    parameter int PRE_W    = 10,
    parameter int SRCH_W   = 10,
    parameter int THR_LOG2 = 28,
    parameter int PROD_W   = PRE_W + 2 * SRCH_W
) (
    input  logic [PRE_W-1:0]  pre_i,
    input  logic [SRCH_W-1:0] trial_i,
    output logic              below_o
);
    localparam logic [PROD_W-1:0] THRESH = PROD_W'(1) << THR_LOG2;

    logic [2*SRCH_W-1:0] sq;
    logic [PROD_W-1:0]   prod;

    assign sq      = {{SRCH_W{1'b0}}, trial_i} * {{SRCH_W{1'b0}}, trial_i};
    assign prod    = PROD_W'(pre_i) * PROD_W'(sq);
    assign below_o = prod < THRESH;
endmodule

// File: rtl/rsq_pack.sv
module rsq_pack #(
    parameter int OP_W   = 9,
    parameter int SRCH_W = 10,
    parameter int WORD_W = 32
) (
    input  logic [SRCH_W-1:0] last_below_i,
    input  logic              sat_i,
    output logic [OP_W-1:0]   est_o,
    output logic [WORD_W-1:0] word_o
);
    // the loop starts at b = 2^OP_W, so b+1 never drops below 2^OP_W + 1
    localparam logic [SRCH_W:0] FLOOR_C = (SRCH_W + 1)'((2 ** OP_W) + 1);

    logic [SRCH_W:0] c_inc;
    logic [SRCH_W:0] c_sel;
    logic            c_unused;

    assign c_inc    = {1'b0, last_below_i} + (SRCH_W + 1)'(1);
    assign c_sel    = (c_inc < FLOOR_C) ? FLOOR_C : c_inc;
    assign c_unused = ^{c_sel[0], c_sel[SRCH_W:OP_W+1]};

    always_comb begin
        if (sat_i) begin
            est_o  = '1;
            word_o = '1;
        end else begin
            est_o  = c_sel[OP_W:1];
            word_o = {c_sel[OP_W:1], {(WORD_W - OP_W){1'b0}}};
        end
    end
endmodule

// File: rtl/rsq_core.sv
module rsq_core
    import rsq_pkg::*;
#(
    parameter int OP_W     = 9,
    parameter int WORD_W   = 32,
    parameter int SRCH_W   = 10,
    parameter int THR_LOG2 = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [OP_W-1:0]   operand_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              done_o,
    output logic [OP_W-1:0]   est_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int PRE_W  = OP_W + 1;
    localparam int PROD_W = PRE_W + 2 * SRCH_W;
    localparam int IDX_W  = $clog2(SRCH_W);

    typedef struct packed {
        rsq_phase_e        phase;
        logic [PRE_W-1:0]  pre;
        logic [SRCH_W-1:0] best;
        logic [IDX_W-1:0]  idx;
        logic              sat;
        logic              done;
        logic [OP_W-1:0]   est;
        logic [WORD_W-1:0] word;
    } state_t;

    state_t s_d, s_q;

    logic [OP_W-1:0]   op_sel;
    logic              sat_req;
    logic [PRE_W-1:0]  pre_w;
    logic [SRCH_W-1:0] trial_w;
    logic              below_w;
    logic [OP_W-1:0]   est_w;
    logic [WORD_W-1:0] word_w;
    logic              word_unused;

    assign op_sel      = mode_i ? word_i[WORD_W-1 -: OP_W] : operand_i;
    assign sat_req     = mode_i && (word_i[WORD_W-1 -: 2] == 2'b00);
    assign word_unused = ^word_i[WORD_W-OP_W-1:0];
    assign trial_w     = s_q.best | (SRCH_W'(1) << s_q.idx);

    rsq_precond #(.OP_W(OP_W), .PRE_W(PRE_W)) i_precond (
        .op_i  (op_sel),
        .pre_o (pre_w)
    );

    rsq_trial #(
        .PRE_W(PRE_W), .SRCH_W(SRCH_W), .THR_LOG2(THR_LOG2), .PROD_W(PROD_W)
    ) i_trial (
        .pre_i   (s_q.pre),
        .trial_i (trial_w),
        .below_o (below_w)
    );

    rsq_pack #(.OP_W(OP_W), .SRCH_W(SRCH_W), .WORD_W(WORD_W)) i_pack (
        .last_below_i (s_q.best),
        .sat_i        (s_q.sat),
        .est_o        (est_w),
        .word_o       (word_w)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_BUSY;
                    s_d.pre   = pre_w;
                    s_d.best  = '0;
                    s_d.idx   = IDX_W'(SRCH_W - 1);
                    s_d.sat   = sat_req;
                end
            end
            PH_BUSY: begin
                if (below_w) begin
                    s_d.best = trial_w;
                end
                if (s_q.idx == '0) begin
                    s_d.phase = PH_FIN;
                end else begin
                    s_d.idx = s_q.idx - IDX_W'(1);
                end
            end
            PH_FIN: begin
                s_d.est   = est_w;
                s_d.word  = word_w;
                s_d.done  = 1'b1;
                s_d.phase = PH_IDLE;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = s_q.done;
    assign est_o  = s_q.est;
    assign word_o = s_q.word;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
    parameter int OP_W   = 9,
    parameter int WORD_W = 32,
    parameter int SRCH_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mode_i,
    input logic [WORD_W-1:0] word_i,
    input logic              done_o,
    input logic [OP_W-1:0]   est_o,
    input logic [WORD_W-1:0] word_o
);
    localparam int LAT   = SRCH_W + 1;
    localparam int CNT_W = $clog2(LAT + 1);

    logic             busy_c;
    logic [CNT_W-1:0] cnt;
    logic             cap_sat;
    logic             accept;
    logic             exp_done;
    logic             word_unused;

    assign word_unused = ^word_i[WORD_W-3:0];
    assign exp_done    = busy_c && (cnt == CNT_W'(LAT));
    assign accept      = start_i && (!busy_c || exp_done);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_c  <= 1'b0;
            cnt     <= '0;
            cap_sat <= 1'b0;
        end else if (accept) begin
            busy_c  <= 1'b1;
            cnt     <= '0;
            cap_sat <= mode_i && (word_i[WORD_W-1 -: 2] == 2'b00);
        end else if (busy_c) begin
            if (exp_done) begin
                busy_c <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assert_done_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exp_done |-> done_o);

    assert_no_extra_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> exp_done);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_est_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cap_sat) |-> est_o[OP_W-1]);

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_sat) |-> (word_o == '1));

    assert_packing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cap_sat) |->
            (word_o[WORD_W-1 -: OP_W] == est_o) && (word_o[WORD_W-OP_W-1:0] == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(est_o) && $stable(word_o)));
endmodule

bind rsq_core rsq_checker #(.OP_W(OP_W), .WORD_W(WORD_W), .SRCH_W(SRCH_W)) i_rsq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .mode_i  (mode_i),
    .word_i  (word_i),
    .done_o  (done_o),
    .est_o   (est_o),
    .word_o  (word_o)
);

// File: tb/test_rsq_core.sv
module test_rsq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [8:0]  operand_i = '0;
    logic [31:0] word_i = '0;
    logic        done_o;
    logic [8:0]  est_o;
    logic [31:0] word_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rsq_core i_rsq_core (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .operand_i(operand_i), .word_i(word_i),
        .done_o(done_o), .est_o(est_o), .word_o(word_o)
    );

    // operand, expected estimate
    localparam logic [17:0] VEC [5] = '{
        {9'd128, 9'd511},
        {9'd255, 9'd362},
        {9'd256, 9'd361},
        {9'd257, 9'd361},
        {9'd511, 9'd256}
    };

    function automatic int ref_est(int a);
        longint p;
        longint b;
        if (a < 256) p = 2 * a + 1;
        else         p = (((a >> 1) << 1) + 1) * 2;
        b = 512;
        while (p * (b + 1) * (b + 1) < (64'd1 << 28)) b++;
        return int'((b + 1) / 2);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // raises start on a falling edge, returns the falling-edge count until done
    task automatic run(input logic md, input logic [8:0] op, input logic [31:0] w,
                       output int lat);
        @(negedge clk);
        mode_i = md; operand_i = op; word_i = w; start_i = 1'b1;
        lat = -1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (done_o) begin
                lat = k;
                break;
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog: actual no completion expected done");
        summary();
        $finish;
    end

    initial begin
        int lat;
        int ndone;
        int exp;
        repeat (3) @(negedge clk);
        check("R10 done in reset", done_o, 0);
        check("R10 est in reset", est_o, 0);
        check("R10 word in reset", word_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table of known points: R2 (255), R3 (256/257), R5 (128, 511)
        for (int i = 0; i < 5; i++) begin
            run(1'b0, VEC[i][17:9], 32'h0, lat);
            check("R2/R3/R5 table estimate", est_o, VEC[i][8:0]);
            check("R8 latency", lat, 12);
        end

        // full sweep of legal operands: R1, R4, R7
        for (int a = 128; a < 512; a++) begin
            run(1'b0, 9'(a), 32'h0, lat);
            exp = ref_est(a);
            check("R4 sweep estimate", est_o, exp);
            if (est_o < 256) check("R1 estimate range", est_o, 256);
            if (a % 64 == 0) check("R7 packed word mode0", word_o, longint'(exp) << 23);
        end

        // R3 pairs agree above 256
        run(1'b0, 9'd300, 32'h0, lat);
        exp = est_o;
        run(1'b0, 9'd301, 32'h0, lat);
        check("R3 pair 300/301", est_o, exp);

        // R8 pulse width
        run(1'b0, 9'd200, 32'h0, lat);
        @(negedge clk);
        check("R8 done single cycle", done_o, 0);
        check("R8 result held", est_o, ref_est(200));

        // 32-bit word mode: R6, R7
        run(1'b1, 9'd0, 32'h3FFF_FFFF, lat);
        check("R6 saturate word", word_o, 32'hFFFF_FFFF);
        check("R6 saturate est", est_o, 9'h1FF);
        run(1'b1, 9'd0, 32'h0000_0000, lat);
        check("R6 zero word", word_o, 32'hFFFF_FFFF);
        run(1'b1, 9'd0, 32'h4000_0000, lat);
        check("R7 word 01 field", word_o, 32'hFF80_0000);
        run(1'b1, 9'd0, 32'hFFFF_FFFF, lat);
        check("R7 word all ones", word_o, 32'h8000_0000);
        run(1'b1, 9'd0, 32'h8000_0000, lat);
        check("R7 word 256", word_o, 32'hB480_0000);
        run(1'b1, 9'd128, 32'h807F_FFFF, lat);
        check("R7 low bits ignored", word_o, 32'hB480_0000);
        check("R7 low bits est", est_o, 9'd361);

        // R9: a second start mid-computation is ignored
        @(negedge clk);
        mode_i = 1'b0; operand_i = 9'd128; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        operand_i = 9'd511; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ndone = 0;
        for (int k = 0; k < 30; k++) begin
            if (done_o) begin
                ndone++;
                check("R9 first result kept", est_o, 511);
            end
            @(negedge clk);
        end
        check("R9 single done pulse", ndone, 1);

        summary();
        $finish;
    end
endmodule